// File: doc/BRIEF.md
# Deep-Idle Sleep Signal Qualifier

This block decides when a platform may enter its deepest idle state. It drives an active-low sleep output, `sleepN`. The output goes low only when every readiness condition that software has not waived is true and no enabled clock-request pin is pulled low. Once low, the output stays low for a programmable minimum number of slow real-time ticks, even if a break event comes earlier.

When the output returns high, an exit-latency timer counts slow ticks. Until that timer runs out, the block can keep holding off three things: power-restore requests, crystal re-enable and PLL re-enable. While the output is low, it can also ask the fast ring-oscillator clocks to stop.

All behaviour is set by one 32-bit configuration register with read/write access. Timing moves forward only on a single-cycle `rtcTick` strobe in the fast clock domain. All condition inputs are assumed to be already synchronous to that domain.

Top module: `sleep_qualifier`

## Requirements
- R1: After reset the configuration reads 0x00000000, `sleepN` is 1, `pwrRestoreBlock`, `pllReenBlock` and `fastOscStop` are 0, and `xtalReenAllow` is 1.
- R2: A configuration write stores every writable bit. Bits 27, 24, 15 and 14 always read 0, so writing 0xFFFFFFFF reads back as 0xF6FF3FFF.
- R3: Six readiness inputs are each required for entry unless their waive bit is 1. The waive bits are: `meGated` bit 31, `lanOff` bit 30, `dspD3` bit 29, `usbD3` bit 28, `thermOff` bit 26, `traceNoAon` bit 12.
- R4: `xtalOff` is required for entry while bit 22 is 0. Setting bit 22 to 1 removes that requirement.
- R5: Bit 16+k enables `clkReqN[k]` as an inhibit. When enabled, a low `clkReqN[k]` prevents entry and also acts as a break event. A pin whose bit is 0 has no effect.
- R6: When entry conditions hold on a clock edge, `sleepN` is 0 after that edge.
- R7: A width code n in bits 11:9 keeps `sleepN` at 0 until n+1 ticks have been counted since entry. After that, `sleepN` returns to 1 on the first edge at which entry conditions no longer hold.
- R8: Exit latency N is held in bits 8:0. With N=0 the post-exit window ends at deassertion. With N>0 the window ends on the edge of the Nth tick after deassertion.
- R9: With bit 23 set, `pwrRestoreBlock` is 1 while entry conditions hold, while `sleepN` is 0, and during the post-exit window. It is 0 otherwise.
- R10: With bit 22 at 0, `xtalReenAllow` is 0 while `sleepN` is 0 and during the post-exit window. It is 1 otherwise.
- R11: With bit 25 set, `pllReenBlock` is 1 while `sleepN` is 0 and during the post-exit window. With bit 25 at 0 it stays 0.
- R12: With bit 13 set, `fastOscStop` is 1 exactly while `sleepN` is 0. With bit 13 at 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration write value |
| cfgRdData | output | 32 | Configuration read value |
| rtcTick | input | 1 | Single-cycle slow tick strobe |
| meGated | input | 1 | Management engine is power gated |
| lanOff | input | 1 | LAN is disconnected |
| dspD3 | input | 1 | Audio DSP is in D3 |
| usbD3 | input | 1 | USB host is in D3 |
| thermOff | input | 1 | Thermal sensor is disabled |
| traceNoAon | input | 1 | Trace hub is not requesting always-on |
| xtalOff | input | 1 | Crystal oscillator is shut down |
| clkReqN | input | 6 | Active-low clock-request pins |
| sleepN | output | 1 | Active-low deep-idle signal |
| pwrRestoreBlock | output | 1 | Hold off power-restore requests |
| xtalReenAllow | output | 1 | Crystal may be re-enabled |
| pllReenBlock | output | 1 | Hold off PLL re-enable |
| fastOscStop | output | 1 | Request fast ring oscillators to stop |

## Verification
The assertions take it for granted that `rtcTick` is high for one clock at most and that condition inputs change only between edges, already synchronous to `clk`. The timer properties rely on the counters being loaded only from the control's strobes. The stimulus drives every input at the falling edge. It raises `rtcTick` for exactly one cycle per tick, with idle cycles in between, and it resets the block before each scenario so that every counter and state starts from a known point.

// File: rtl/sleep_qual_pkg.sv
package sleep_qual_pkg;

  localparam int QUAL_N      = 6;
  localparam int CLKREQ_N    = 6;
  localparam int WIDTH_BITS  = 3;
  localparam int LAT_BITS    = 9;

  // waive-bit positions, index 0 = trace, 1 = thermal, 2 = usb, 3 = dsp, 4 = lan, 5 = me
  localparam int QUAL_WAIVE_POS [QUAL_N] = '{12, 26, 28, 29, 30, 31};

  localparam int CLKREQ_LSB   = 16;
  localparam int XTAL_WAIVE   = 22;
  localparam int PWR_BLK_EN   = 23;
  localparam int PLL_BLK_EN   = 25;
  localparam int LOWV_EN      = 13;
  localparam int WIDTH_LSB    = 9;
  localparam int LAT_LSB      = 0;

  localparam logic [31:0] CFG_WR_MASK = ~((32'h1 << 27) | (32'h1 << 24) | (32'h3 << 14));

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_EXIT = 2'd2
  } sleepState_t;

  typedef struct packed {
    logic loadWidth;
    logic loadExit;
    logic inAssert;
    logic inExit;
  } ctrlStrb_t;

endpackage

// File: rtl/sleep_qual_dp.sv
module sleep_qual_dp
  import sleep_qual_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [31:0]         cfgWrData,
  output logic [31:0]         cfgRdData,
  input  logic                rtcTick,
  input  logic [QUAL_N-1:0]   qualIn,
  input  logic                xtalOff,
  input  logic [CLKREQ_N-1:0] clkReqN,
  input  ctrlStrb_t           strb,
  output logic                entryOk,
  output logic                widthDone,
  output logic                exitOne,
  output logic                latZero,
  output logic                sleepN,
  output logic                pwrRestoreBlock,
  output logic                xtalReenAllow,
  output logic                pllReenBlock,
  output logic                fastOscStop
);

  localparam int WCNT_BITS = WIDTH_BITS + 1;

  logic [31:0]          cfgReg;
  logic [QUAL_N-1:0]    qualMet;
  logic [CLKREQ_N-1:0]  reqMask;
  logic                 reqInhibit;
  logic                 xtalMet;
  logic [WIDTH_BITS-1:0] widthCode;
  logic [LAT_BITS-1:0]  latVal;
  logic [WCNT_BITS-1:0] widthCnt;
  logic [LAT_BITS-1:0]  exitCnt;
  logic                 inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWrEn) cfgReg <= cfgWrData & CFG_WR_MASK;
  end
  assign cfgRdData = cfgReg;

  for (genvar i = 0; i < QUAL_N; i++) begin : gQual
    assign qualMet[i] = qualIn[i] | cfgReg[QUAL_WAIVE_POS[i]];
  end

  assign reqMask    = cfgReg[CLKREQ_LSB +: CLKREQ_N];
  assign reqInhibit = |(~clkReqN & reqMask);
  assign xtalMet    = xtalOff | cfgReg[XTAL_WAIVE];
  assign entryOk    = (&qualMet) & xtalMet & ~reqInhibit;

  assign widthCode = cfgReg[WIDTH_LSB +: WIDTH_BITS];
  assign latVal    = cfgReg[LAT_LSB +: LAT_BITS];
  assign latZero   = (latVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) widthCnt <= '0;
    else if (strb.loadWidth) widthCnt <= WCNT_BITS'(widthCode) + WCNT_BITS'(1);
    else if (rtcTick && widthCnt != '0) widthCnt <= widthCnt - WCNT_BITS'(1);
  end
  assign widthDone = (widthCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) exitCnt <= '0;
    else if (strb.loadExit) exitCnt <= latVal;
    else if (rtcTick && exitCnt != '0) exitCnt <= exitCnt - LAT_BITS'(1);
  end
  assign exitOne = (exitCnt == LAT_BITS'(1));

  assign inWindow        = strb.inAssert | strb.inExit;
  assign sleepN          = ~strb.inAssert;
  assign pwrRestoreBlock = cfgReg[PWR_BLK_EN] & (entryOk | inWindow);
  assign xtalReenAllow   = ~(~cfgReg[XTAL_WAIVE] & inWindow);
  assign pllReenBlock    = cfgReg[PLL_BLK_EN] & inWindow;
  assign fastOscStop     = cfgReg[LOWV_EN] & strb.inAssert;

  p_width_no_grow_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadWidth |=> widthCnt <= $past(widthCnt));

  p_exit_no_grow_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadExit |=> exitCnt <= $past(exitCnt));

endmodule

// File: rtl/sleep_qual_ctrl.sv
module sleep_qual_ctrl
  import sleep_qual_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rtcTick,
  input  logic      entryOk,
  input  logic      widthDone,
  input  logic      exitOne,
  input  logic      latZero,
  output ctrlStrb_t strb
);

  sleepState_t state, stateNx;

  always_comb begin
    stateNx        = state;
    strb.loadWidth = 1'b0;
    strb.loadExit  = 1'b0;
    case (state)
      ST_IDLE: if (entryOk) begin
        stateNx        = ST_ON;
        strb.loadWidth = 1'b1;
      end
      ST_ON: if (widthDone && !entryOk) begin
        stateNx       = latZero ? ST_IDLE : ST_EXIT;
        strb.loadExit = ~latZero;
      end
      ST_EXIT: begin
        if (entryOk) begin
          stateNx        = ST_ON;
          strb.loadWidth = 1'b1;
        end else if (rtcTick && exitOne) begin
          stateNx = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  assign strb.inAssert = (state == ST_ON);
  assign strb.inExit   = (state == ST_EXIT);

  p_entry_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !entryOk) |=> state == ST_IDLE);

  p_min_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && !widthDone) |=> state == ST_ON);

  p_exit_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXIT && !rtcTick && !entryOk) |=> state == ST_EXIT);

endmodule

// File: rtl/sleep_qualifier.sv
module sleep_qualifier
  import sleep_qual_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        rtcTick,
  input  logic        meGated,
  input  logic        lanOff,
  input  logic        dspD3,
  input  logic        usbD3,
  input  logic        thermOff,
  input  logic        traceNoAon,
  input  logic        xtalOff,
  input  logic [5:0]  clkReqN,
  output logic        sleepN,
  output logic        pwrRestoreBlock,
  output logic        xtalReenAllow,
  output logic        pllReenBlock,
  output logic        fastOscStop
);

  ctrlStrb_t         strb;
  logic              entryOk, widthDone, exitOne, latZero;
  logic [QUAL_N-1:0] qualIn;

  assign qualIn = {meGated, lanOff, dspD3, usbD3, thermOff, traceNoAon};

  sleep_qual_dp u_dp (
    .clk, .rstN, .cfgWrEn, .cfgWrData, .cfgRdData, .rtcTick,
    .qualIn, .xtalOff, .clkReqN, .strb,
    .entryOk, .widthDone, .exitOne, .latZero,
    .sleepN, .pwrRestoreBlock, .xtalReenAllow, .pllReenBlock, .fastOscStop
  );

  sleep_qual_ctrl u_ctrl (
    .clk, .rstN, .rtcTick, .entryOk, .widthDone, .exitOne, .latZero, .strb
  );

  p_fell_needs_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepN) |-> $past(entryOk));

  p_lowv_only_asleep_r12: assert property (@(posedge clk) disable iff (!rstN)
    fastOscStop |-> !sleepN);

endmodule

// File: tb/sleep_qualifier_tb.sv
module sleep_qualifier_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        rtcTick = 1'b0;
  logic        meGated = 1'b0, lanOff = 1'b0, dspD3 = 1'b0, usbD3 = 1'b0;
  logic        thermOff = 1'b0, traceNoAon = 1'b0, xtalOff = 1'b0;
  logic [5:0]  clkReqN = 6'h3f;
  logic        sleepN, pwrRestoreBlock, xtalReenAllow, pllReenBlock, fastOscStop;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_qualifier u_dut (
    .clk, .rstN, .cfgWrEn, .cfgWrData, .cfgRdData, .rtcTick,
    .meGated, .lanOff, .dspD3, .usbD3, .thermOff, .traceNoAon, .xtalOff,
    .clkReqN, .sleepN, .pwrRestoreBlock, .xtalReenAllow, .pllReenBlock, .fastOscStop
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setQual(input logic [5:0] v);
    {meGated, lanOff, dspD3, usbD3, thermOff, traceNoAon} = v;
  endtask

  task automatic allReady();
    setQual(6'h3f);
    xtalOff = 1'b1;
    clkReqN = 6'h3f;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    setQual(6'h0);
    xtalOff = 1'b0;
    clkReqN = 6'h3f;
    rtcTick = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic wrCfg(input logic [31:0] v);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    step(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic tickOnce();
    rtcTick = 1'b1;
    step(1);
    rtcTick = 1'b0;
    step(1);
  endtask

  task automatic tReset();
    doReset();
    chk(cfgRdData == 32'h0, "R1 cfg", cfgRdData, 32'h0);
    chk({sleepN, pwrRestoreBlock, xtalReenAllow, pllReenBlock, fastOscStop} == 5'b10100,
        "R1 outputs", {sleepN, pwrRestoreBlock, xtalReenAllow, pllReenBlock, fastOscStop}, 5'b10100);
  endtask

  task automatic tCfg();
    doReset();
    wrCfg(32'hFFFF_FFFF);
    chk(cfgRdData == 32'hF6FF_3FFF, "R2 reserved", cfgRdData, 32'hF6FF_3FFF);
    wrCfg(32'h1234_5678);
    chk(cfgRdData == (32'h1234_5678 & 32'hF6FF_3FFF), "R2 pattern", cfgRdData, 32'h1234_5678 & 32'hF6FF_3FFF);
  endtask

  task automatic tQual();
    int pos [6] = '{12, 26, 28, 29, 30, 31};
    for (int i = 0; i < 6; i++) begin
      doReset();
      allReady();
      setQual(6'h3f & ~(6'h1 << i));
      step(2);
      chk(sleepN == 1'b1, $sformatf("R3 missing qual %0d", i), sleepN, 1'b1);
      wrCfg(32'h1 << pos[i]);
      step(1);
      chk(sleepN == 1'b0, $sformatf("R3 waived qual %0d", i), sleepN, 1'b0);
    end
  endtask

  task automatic tXtal();
    doReset();
    allReady();
    xtalOff = 1'b0;
    step(2);
    chk(sleepN == 1'b1, "R4 crystal required", sleepN, 1'b1);
    wrCfg(32'h1 << 22);
    step(1);
    chk(sleepN == 1'b0, "R4 crystal waived", sleepN, 1'b0);
    chk(xtalReenAllow == 1'b1, "R10 waived allows", xtalReenAllow, 1'b1);
  endtask

  task automatic tClkReq();
    doReset();
    wrCfg(32'h0008_0000);
    allReady();
    clkReqN = 6'b110111;
    step(2);
    chk(sleepN == 1'b1, "R5 enabled pin inhibits", sleepN, 1'b1);
    clkReqN = 6'b111011;
    step(1);
    chk(sleepN == 1'b0, "R5 unmasked pin ignored", sleepN, 1'b0);
    tickOnce();
    clkReqN = 6'b110111;
    step(1);
    chk(sleepN == 1'b1, "R5 break event", sleepN, 1'b1);
  endtask

  task automatic tWidth();
    doReset();
    wrCfg((32'h2 << 9) | (32'h1 << 23));
    allReady();
    step(1);
    chk(sleepN == 1'b0, "R6 entry next edge", sleepN, 1'b0);
    meGated = 1'b0;
    tickOnce();
    tickOnce();
    step(3);
    chk(sleepN == 1'b0, "R7 held after two ticks", sleepN, 1'b0);
    chk(pwrRestoreBlock == 1'b1, "R9 block while asserted", pwrRestoreBlock, 1'b1);
    rtcTick = 1'b1;
    step(1);
    rtcTick = 1'b0;
    chk(sleepN == 1'b0, "R7 held on third tick edge", sleepN, 1'b0);
    step(1);
    chk(sleepN == 1'b1, "R7 released after width", sleepN, 1'b1);
    chk(pwrRestoreBlock == 1'b0, "R8 zero latency release", pwrRestoreBlock, 1'b0);
  endtask

  task automatic tExit();
    doReset();
    wrCfg(32'd3 | (32'h1 << 23) | (32'h1 << 25));
    allReady();
    step(1);
    chk(pllReenBlock == 1'b1, "R11 pll block asserted", pllReenBlock, 1'b1);
    chk(xtalReenAllow == 1'b0, "R10 crystal held asserted", xtalReenAllow, 1'b0);
    tickOnce();
    meGated = 1'b0;
    step(1);
    chk(sleepN == 1'b1, "R8 deasserted", sleepN, 1'b1);
    chk({pwrRestoreBlock, xtalReenAllow, pllReenBlock} == 3'b101, "R9 R10 R11 exit window",
        {pwrRestoreBlock, xtalReenAllow, pllReenBlock}, 3'b101);
    tickOnce();
    tickOnce();
    chk({pwrRestoreBlock, xtalReenAllow, pllReenBlock} == 3'b101, "R8 still blocked after two ticks",
        {pwrRestoreBlock, xtalReenAllow, pllReenBlock}, 3'b101);
    tickOnce();
    chk({pwrRestoreBlock, xtalReenAllow, pllReenBlock} == 3'b010, "R8 released on third tick",
        {pwrRestoreBlock, xtalReenAllow, pllReenBlock}, 3'b010);
  endtask

  task automatic tLowVolt();
    doReset();
    allReady();
    step(1);
    chk(fastOscStop == 1'b0, "R12 disabled", fastOscStop, 1'b0);
    chk(pllReenBlock == 1'b0, "R11 disabled", pllReenBlock, 1'b0);
    doReset();
    wrCfg(32'h1 << 13);
    chk(fastOscStop == 1'b0, "R12 idle", fastOscStop, 1'b0);
    allReady();
    step(1);
    chk(fastOscStop == 1'b1, "R12 asserted", fastOscStop, 1'b1);
  endtask

  initial begin
    tReset();
    tCfg();
    tQual();
    tXtal();
    tClkReq();
    tWidth();
    tExit();
    tLowVolt();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule